// File: doc/BRIEF.md
# Hashed Page-Table Lookup Engine

When the translation cache misses, this engine resolves a virtual page number for a given process through a hashed translation table in memory, with no software help. It folds the page number and the process identifier into a slot index and adds that index to a table base to form the slot's address. It then fetches the slot's entries one word at a time, in order, until one of them carries the same page number and process identifier. When the first slot holds no such entry, a second hash selects another slot, and that slot is searched in the same way.

When neither slot resolves the page, the engine reports an unresolved miss, and software then walks its complete backup table. A hit returns the physical page number together with a flag that tells whether the primary or the alternate slot supplied it. Memory is reached through a plain word-read port. The engine keeps one request in flight at a time and waits for each response before it issues the next address. Addresses on that port are word addresses: each entry takes one word, and a slot is a run of consecutive words.

Top module: `hpt_walker`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mem_req_valid` and `res_hit` are all 0.
- R2: The first read of a lookup goes to word address `table_base + P*SLOT_ENTRIES`, where the primary slot P = (vpn XOR pid) mod NUM_SLOTS.
- R3: Entries are read one word at a time at consecutive addresses, starting with entry 0. A new request is raised only after the response to the previous one has arrived, so at most one read is outstanding.
- R4: An entry word is laid out as {valid (MSB), pid (PID_W bits), vpn (VPN_W bits), ppn (PPN_W bits, LSBs)}. An entry matches only when valid is 1 and both its pid and its vpn equal the lookup's. An entry that is invalid, or that differs in pid alone, never matches.
- R5: The search stops at the first matching entry. `done` then pulses with `res_hit`=1, `res_secondary`=0 and that entry's ppn, after exactly (match position + 1) reads.
- R6: When no entry of the primary slot matches, the engine searches the alternate slot S = (NOT P) mod NUM_SLOTS from entry 0, and a hit found there reports `res_secondary`=1.
- R7: When neither slot matches, `done` pulses with `res_hit`=0 and `res_secondary`=0 after exactly 2*SLOT_ENTRIES reads, and no other slot is read.
- R8: `start` is taken only while `busy` is 0. A `start` raised during a lookup changes neither that lookup's reads nor its result, and it produces no further `done`.
- R9: `done` is high for a single cycle. The result outputs hold their values until the next accepted `start`, which clears `res_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken when not busy) |
| vpn_in | input | VPN_W | Virtual page number to resolve |
| pid_in | input | PID_W | Process identifier of the lookup |
| table_base | input | PA_W | Word address of slot 0 of the table |
| busy | output | 1 | A lookup is in progress |
| mem_req_valid | output | 1 | Single-cycle read request |
| mem_req_addr | output | PA_W | Word address of the read |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 1+PID_W+VPN_W+PPN_W | Entry word returned by memory |
| done | output | 1 | One-cycle pulse when a lookup ends |
| res_hit | output | 1 | The translation was found |
| res_secondary | output | 1 | The hit came from the alternate slot |
| res_ppn | output | PPN_W | Physical page number of the hit |

## Verification
The first directed pattern fills the primary slot with decoys ahead of the real entry: a word whose pid alone differs, an invalid word with a matching tag, and a word whose vpn is off by one bit. A later duplicate match sits behind the real entry. Together these show that both tag fields and the valid bit are compared, that entries are visited in order, and that the search stops early. A second pattern fills the primary slot with non-matching entries and plants the hit late in the alternate slot, under a slower memory. This shows the complemented index, the restart at entry 0 and the source flag. A third pattern places a matching entry only in an unrelated slot, which tells a true two-slot search apart from a wider scan. Further tests raise `start` during a running lookup and watch the result registers after `done`.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;

    localparam int DEF_VPN_W   = 20;
    localparam int DEF_PID_W   = 8;
    localparam int DEF_PPN_W   = 20;
    localparam int DEF_PA_W    = 32;
    localparam int DEF_SLOTS   = 16;
    localparam int DEF_ENTRIES = 8;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2
    } walk_state_e;

    typedef enum logic {
        SLOT_PRIMARY   = 1'b0,
        SLOT_ALTERNATE = 1'b1
    } slot_pick_e;

endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash #(
    parameter int IDX_W = 4,
    parameter int KEY_W = 4
) (
    input  logic [IDX_W-1:0] vpn_lo,
    input  logic [KEY_W-1:0] pid_lo,
    output logic [IDX_W-1:0] pri_idx,
    output logic [IDX_W-1:0] alt_idx
);
    logic [IDX_W-1:0] pid_ext;

    generate
        if (KEY_W < IDX_W) begin : g_pad
            assign pid_ext = {{(IDX_W-KEY_W){1'b0}}, pid_lo};
        end else begin : g_full
            assign pid_ext = pid_lo;
        end
    endgenerate

    assign pri_idx = vpn_lo ^ pid_ext;
    assign alt_idx = ~pri_idx;
endmodule

// File: rtl/hpt_entry_cmp.sv
`timescale 1ns/1ps
module hpt_entry_cmp #(
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PPN_W = 20
) (
    input  logic [PID_W+VPN_W+PPN_W:0] word,
    input  logic [VPN_W-1:0]           vpn,
    input  logic [PID_W-1:0]           pid,
    output logic                       match,
    output logic [PPN_W-1:0]           ppn
);
    logic             e_valid;
    logic [PID_W-1:0] e_pid;
    logic [VPN_W-1:0] e_vpn;

    assign {e_valid, e_pid, e_vpn, ppn} = word;
    assign match = e_valid && (e_pid == pid) && (e_vpn == vpn);
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int VPN_W        = DEF_VPN_W,
    parameter int PID_W        = DEF_PID_W,
    parameter int PPN_W        = DEF_PPN_W,
    parameter int PA_W         = DEF_PA_W,
    parameter int NUM_SLOTS    = DEF_SLOTS,
    parameter int SLOT_ENTRIES = DEF_ENTRIES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [VPN_W-1:0]               vpn_in,
    input  logic [PID_W-1:0]               pid_in,
    input  logic [PA_W-1:0]                table_base,
    output logic                           busy,
    output logic                           mem_req_valid,
    output logic [PA_W-1:0]                mem_req_addr,
    input  logic                           mem_rsp_valid,
    input  logic [PID_W+VPN_W+PPN_W:0]     mem_rsp_data,
    output logic                           done,
    output logic                           res_hit,
    output logic                           res_secondary,
    output logic [PPN_W-1:0]               res_ppn
);
    localparam int IDX_W  = $clog2(NUM_SLOTS);
    localparam int ENT_W  = $clog2(SLOT_ENTRIES);
    localparam int KEY_W  = (PID_W < IDX_W) ? PID_W : IDX_W;
    localparam int CNT_W  = ENT_W + 2;
    localparam int TBL_WORDS = NUM_SLOTS * SLOT_ENTRIES;
    localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(SLOT_ENTRIES - 1);
    localparam logic [CNT_W-1:0] READS_ALL = CNT_W'(2 * SLOT_ENTRIES);
    localparam logic [CNT_W-1:0] READS_ONE = CNT_W'(SLOT_ENTRIES);

    typedef struct packed {
        logic             hit;
        logic             secondary;
        logic [PPN_W-1:0] ppn;
    } result_t;

    walk_state_e      state;
    slot_pick_e       slot_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PID_W-1:0] pid_q;
    logic [PA_W-1:0]  base_q;
    logic [ENT_W-1:0] ent_q;
    result_t          res_q;
    logic             done_q;
    logic [CNT_W-1:0] rd_cnt;

    logic [IDX_W-1:0] pri_idx, alt_idx, cur_idx;
    logic             ent_match;
    logic [PPN_W-1:0] ent_ppn;
    logic             accept;

    hpt_hash #(
        .IDX_W (IDX_W),
        .KEY_W (KEY_W)
    ) u_hash (
        .vpn_lo  (vpn_q[IDX_W-1:0]),
        .pid_lo  (pid_q[KEY_W-1:0]),
        .pri_idx (pri_idx),
        .alt_idx (alt_idx)
    );

    hpt_entry_cmp #(
        .VPN_W (VPN_W),
        .PID_W (PID_W),
        .PPN_W (PPN_W)
    ) u_cmp (
        .word  (mem_rsp_data),
        .vpn   (vpn_q),
        .pid   (pid_q),
        .match (ent_match),
        .ppn   (ent_ppn)
    );

    assign accept        = (state == WS_IDLE) && start;
    assign cur_idx       = (slot_q == SLOT_ALTERNATE) ? alt_idx : pri_idx;
    assign mem_req_valid = (state == WS_ISSUE);
    assign mem_req_addr  = base_q + PA_W'({cur_idx, ent_q});
    assign busy          = (state != WS_IDLE);
    assign done          = done_q;
    assign res_hit       = res_q.hit;
    assign res_secondary = res_q.secondary;
    assign res_ppn       = res_q.ppn;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WS_IDLE;
            slot_q <= SLOT_PRIMARY;
            vpn_q  <= '0;
            pid_q  <= '0;
            base_q <= '0;
            ent_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                WS_IDLE: begin
                    if (start) begin
                        vpn_q  <= vpn_in;
                        pid_q  <= pid_in;
                        base_q <= table_base;
                        ent_q  <= '0;
                        slot_q <= SLOT_PRIMARY;
                        res_q  <= '0;
                        state  <= WS_ISSUE;
                    end
                end
                WS_ISSUE: state <= WS_WAIT;
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ent_match) begin
                            res_q.hit       <= 1'b1;
                            res_q.secondary <= (slot_q == SLOT_ALTERNATE);
                            res_q.ppn       <= ent_ppn;
                            done_q          <= 1'b1;
                            state           <= WS_IDLE;
                        end else if (ent_q == LAST_ENT) begin
                            if (slot_q == SLOT_PRIMARY) begin
                                slot_q <= SLOT_ALTERNATE;
                                ent_q  <= '0;
                                state  <= WS_ISSUE;
                            end else begin
                                done_q <= 1'b1;
                                state  <= WS_IDLE;
                            end
                        end else begin
                            ent_q <= ent_q + 1'b1;
                            state <= WS_ISSUE;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Per-lookup read tally, kept for the checks below.
    always_ff @(posedge clk) begin
        if (rst || accept) rd_cnt <= '0;
        else if (mem_req_valid) rd_cnt <= rd_cnt + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req_valid && !res_hit));

    assert_addr_in_table_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> ((mem_req_addr - base_q) < PA_W'(TBL_WORDS)));

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_primary_hit_early_R5: assert property (@(posedge clk) disable iff (rst)
        (done && res_hit && !res_secondary) |-> (rd_cnt <= READS_ONE));

    assert_alternate_after_primary_R6: assert property (@(posedge clk) disable iff (rst)
        (done && res_secondary) |-> (res_hit && rd_cnt > READS_ONE));

    assert_miss_reads_all_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !res_hit) |-> (rd_cnt == READS_ALL));

    assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy == 1'b0 && $past(busy) == 1'b0 && !$past(start)) |-> $stable(res_q));
endmodule

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
    localparam int VW = 20, PW = 8, NW = 20, AW = 32, NS = 16, NE = 8;
    localparam int WW = 1 + PW + VW + NW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, start, busy, mem_req_valid, mem_rsp_valid;
    logic          done, res_hit, res_secondary;
    logic [VW-1:0] vpn_in;
    logic [PW-1:0] pid_in;
    logic [AW-1:0] table_base, mem_req_addr;
    logic [WW-1:0] mem_rsp_data;
    logic [NW-1:0] res_ppn;

    hpt_walker #(.VPN_W(VW), .PID_W(PW), .PPN_W(NW), .PA_W(AW),
                 .NUM_SLOTS(NS), .SLOT_ENTRIES(NE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .vpn_in(vpn_in), .pid_in(pid_in),
        .table_base(table_base), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .res_hit(res_hit),
        .res_secondary(res_secondary), .res_ppn(res_ppn));

    int checks = 0, errors = 0;
    logic [WW-1:0] mem [0:1023];
    logic [AW-1:0] rd_addr [0:511];
    int   n_reads;
    int   mem_lat = 0;
    logic pend;
    int   wait_left;
    logic [AW-1:0] addr_q;

    // Memory model: one response per request, after mem_lat extra cycles.
    always @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0; mem_rsp_valid <= 1'b0; n_reads <= 0; wait_left <= 0;
            mem_rsp_data <= '0; addr_q <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid) begin
                pend <= 1'b1; wait_left <= mem_lat; addr_q <= mem_req_addr;
                rd_addr[n_reads[8:0]] <= mem_req_addr;
                n_reads <= n_reads + 1;
            end else if (pend) begin
                if (wait_left == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[addr_q[9:0]];
                    pend <= 1'b0;
                end else begin
                    wait_left <= wait_left - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mk(input bit v, input logic [PW-1:0] p,
                                         input logic [VW-1:0] vp, input logic [NW-1:0] pp);
        return {v, p, vp, pp};
    endfunction

    function automatic int pri_slot(input logic [VW-1:0] vp, input logic [PW-1:0] p);
        return (int'(vp) ^ int'(p)) % NS;
    endfunction

    function automatic int alt_slot(input logic [VW-1:0] vp, input logic [PW-1:0] p);
        return NS - 1 - pri_slot(vp, p);
    endfunction

    function automatic logic [AW-1:0] waddr(input logic [AW-1:0] b, input int s, input int e);
        return b + AW'(s * NE + e);
    endfunction

    task automatic put(input logic [AW-1:0] b, input int s, input int e, input logic [WW-1:0] w);
        logic [AW-1:0] a;
        a = waddr(b, s, e);
        mem[a[9:0]] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    task automatic start_lookup(input logic [VW-1:0] vp, input logic [PW-1:0] p,
                                input logic [AW-1:0] b);
        @(negedge clk);
        vpn_in = vp; pid_in = p; table_base = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int i;
        for (i = 0; i < 600; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk({tag, " done reached"}, 64'(i < 600), 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 0);
        chk("R1 res_hit", 64'(res_hit), 0);
    endtask

    task automatic t_primary_hit();
        logic [VW-1:0] v = 20'h12345;
        logic [PW-1:0] p = 8'h2A;
        logic [AW-1:0] b = 32'h1000_0180;
        int s = pri_slot(v, p), n0;
        clear_mem(); mem_lat = 0;
        put(b, s, 0, mk(1, p ^ 8'h01, v, 20'h00111));
        put(b, s, 1, mk(0, p, v, 20'h00222));
        put(b, s, 2, mk(1, p, v ^ 20'h1, 20'h00333));
        put(b, s, 3, mk(1, p, v, 20'hABCDE));
        put(b, s, 5, mk(1, p, v, 20'h55555));
        put(b, alt_slot(v, p), 0, mk(1, p, v, 20'h77777));
        n0 = n_reads;
        start_lookup(v, p, b);
        chk("R9 res_hit cleared on start", 64'(res_hit), 0);
        wait_done("R5 primary");
        chk("R5 hit", 64'(res_hit), 1);
        chk("R5 secondary flag", 64'(res_secondary), 0);
        chk("R4 R5 ppn first valid full match", 64'(res_ppn), 64'h0ABCDE);
        @(negedge clk);
        chk("R5 read count", 64'(n_reads - n0), 4);
        chk("R2 first address", 64'(rd_addr[n0]), 64'(waddr(b, s, 0)));
        for (int e = 1; e < 4; e++)
            chk("R3 sequential address", 64'(rd_addr[n0 + e]), 64'(waddr(b, s, e)));
    endtask

    task automatic t_alternate_hit();
        logic [VW-1:0] v = 20'h00ABC;
        logic [PW-1:0] p = 8'h13;
        logic [AW-1:0] b = 32'h0;
        int s = pri_slot(v, p), a = alt_slot(v, p), n0;
        clear_mem(); mem_lat = 3;
        for (int e = 0; e < NE; e++) put(b, s, e, mk(1, p, v + 20'(e + 1), 20'h01000 + 20'(e)));
        put(b, a, 6, mk(1, p, v, 20'h0F00D));
        put(b, a, 7, mk(1, p, v, 20'h0BEEF));
        n0 = n_reads;
        start_lookup(v, p, b);
        wait_done("R6 alternate");
        chk("R6 hit", 64'(res_hit), 1);
        chk("R6 secondary flag", 64'(res_secondary), 1);
        chk("R6 ppn", 64'(res_ppn), 64'h0F00D);
        @(negedge clk);
        chk("R6 read count", 64'(n_reads - n0), 15);
        chk("R3 last primary address", 64'(rd_addr[n0 + 7]), 64'(waddr(b, s, 7)));
        chk("R6 alternate restarts at entry 0", 64'(rd_addr[n0 + 8]), 64'(waddr(b, a, 0)));
        chk("R6 alternate entry 6", 64'(rd_addr[n0 + 14]), 64'(waddr(b, a, 6)));
    endtask

    task automatic t_miss();
        logic [VW-1:0] v = 20'h7FFFF;
        logic [PW-1:0] p = 8'hFF;
        logic [AW-1:0] b = 32'h0000_0200;
        int s = pri_slot(v, p), a = alt_slot(v, p), n0;
        clear_mem(); mem_lat = 1;
        for (int e = 0; e < NE; e++) begin
            put(b, s, e, mk(1, 8'h00, v, 20'h0AAAA));
            put(b, a, e, mk(1, 8'h01, v, 20'h0BBBB));
        end
        put(b, (s + 2) % NS, 0, mk(1, p, v, 20'h0CCCC));
        n0 = n_reads;
        start_lookup(v, p, b);
        wait_done("R7 miss");
        chk("R7 hit", 64'(res_hit), 0);
        chk("R7 secondary flag", 64'(res_secondary), 0);
        @(negedge clk);
        chk("R7 read count", 64'(n_reads - n0), 16);
        chk("R7 final address", 64'(rd_addr[n0 + 15]), 64'(waddr(b, a, 7)));
    endtask

    task automatic t_busy_ignore();
        logic [VW-1:0] v = 20'h12345, v2 = 20'h00042;
        logic [PW-1:0] p = 8'h2A, p2 = 8'h07;
        logic [AW-1:0] b = 32'h1000_0180;
        int s = pri_slot(v, p), n0, extra_done = 0;
        clear_mem(); mem_lat = 2;
        put(b, s, 3, mk(1, p, v, 20'hABCDE));
        put(b, pri_slot(v2, p2), 0, mk(1, p2, v2, 20'h99999));
        n0 = n_reads;
        start_lookup(v, p, b);
        repeat (3) @(negedge clk);
        vpn_in = v2; pid_in = p2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 busy");
        chk("R8 result of first lookup", 64'(res_ppn), 64'h0ABCDE);
        @(negedge clk);
        chk("R8 read count unchanged", 64'(n_reads - n0), 4);
        for (int i = 0; i < 60; i++) begin
            if (done) extra_done++;
            @(negedge clk);
        end
        chk("R8 no second done", 64'(extra_done), 0);
        chk("R8 no reads after", 64'(n_reads - n0), 4);
    endtask

    task automatic t_done_hold();
        logic [VW-1:0] v = 20'h00F0F;
        logic [PW-1:0] p = 8'h33;
        logic [AW-1:0] b = 32'h0;
        int held_bad = 0;
        clear_mem(); mem_lat = 0;
        put(b, pri_slot(v, p), 0, mk(1, p, v, 20'h13579));
        start_lookup(v, p, b);
        wait_done("R9 hold");
        @(negedge clk);
        chk("R9 done is one cycle", 64'(done), 0);
        for (int i = 0; i < 10; i++) begin
            if (res_ppn !== 20'h13579 || res_hit !== 1'b1) held_bad++;
            @(negedge clk);
        end
        chk("R9 result held", 64'(held_bad), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; vpn_in = '0; pid_in = '0; table_base = '0;
        clear_mem();
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_primary_hit();
        t_alternate_hit();
        t_miss();
        t_busy_ignore();
        t_done_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule